// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block controls sixteen general-purpose pins arranged as two groups of eight. A byte-wide register bus configures each pin. The bus has an address, write data, a write strobe, a read strobe and read data. Each pin has two control registers. The drive register sets direction, drive style, pull configuration and the value to drive. The sense register selects which edges raise an interrupt, and its bit 0 returns the current pin level.

Pin inputs pass through a two-stage synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. A detected edge on an enabled pin sets a sticky pending bit. Each group has its own pending register, and software clears bits by writing back the value it read. A per-group mask register decides which pending bits may reach the single registered interrupt line. Drive style and pull settings are not applied to any pad. They are exported as static configuration outputs for the pad ring.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the following hold: every pin_oe bit is 0 and irq is 0. Every drive and sense register reads 0 apart from the live level in bit 0. Both pending registers read 0x00. Both interrupt mask registers and both auxiliary mask registers read 0xFF.
- R2: Pin p uses group g = p/8 and index i = p%8. Its drive register is at 0x2B + 16*g + i and keeps write-data bits 5:0. Its sense register is at 0x33 + 16*g + i and keeps write-data bits 2:1. Reads of any address outside the map return 0x00.
- R3: bus_rdata is loaded on the clock edge that samples bus_rd high and holds its value until the next read.
- R4: Drive register bit 5 = 1 makes the pin an output and bit 0 is the value driven on pin_out. With bit 4 = 0 (push-pull), pin_oe equals bit 5.
- R5: With drive register bit 4 = 1 (open-drain), pin_oe is 1 only when bit 5 = 1 and bit 0 = 0. The pin is never driven high.
- R6: pin_od mirrors drive bit 4 and pin_pull_en mirrors drive bit 3. pin_pull_sel[2p+1:2p] mirrors drive bits 2:1, where 0 = strong down, 1 = strong up, 2 = weak down and 3 = weak up.
- R7: Sense register bit 0 returns the pin level after a two-flop synchroniser.
- R8: Sense bits 2:1 select edge detection: 0 = off, 1 = falling, 2 = rising, 3 = both. A detected edge on pin p sets bit i of the pending register at 0x0B + g.
- R9: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R10: If an edge is detected in the same cycle as a clearing write to that bit, the bit stays set.
- R11: The interrupt mask registers are at 0x19 + g, and a 1 masks that pin. Pending bits are still set while masked.
- R12: irq is a register that is high one cycle after any pending bit whose mask bit is 0 is set. It falls once no such bit remains.
- R13: The auxiliary mask registers at 0x1B + g are plain read/write storage with reset value 0xFF. They have no effect on irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Value to drive per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_od | output | 16 | Open-drain selection per pin |
| pin_pull_en | output | 16 | Pull resistor enable per pin |
| pin_pull_sel | output | 32 | Pull type per pin, two bits each |
| irq | output | 1 | Combined interrupt |

## Verification
The bench times a pin edge so that it reaches the pending register in the same cycle as a write that clears that bit. A design in which the clear has priority would lose that interrupt. The bench also sets pending bits while the pin is masked and then unmasks it. A design that gated detection with the mask would raise no interrupt at that point. Partial write-backs show whether clearing affects only the bits written as 1. Writes to the auxiliary mask registers show whether the second mask pair is wrongly wired into the interrupt. Each detection mode is exercised in both edge directions, so a swapped rising/falling code reads back a wrong pending value.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, types and address helpers for the GPIO bank controller.
// Assumes eight pins per group and a byte-wide register bus.
package gpio_bank_pkg;

    localparam int GRP_PINS = 8;
    localparam int BUS_W    = 8;

    localparam logic [7:0] PEND_BASE  = 8'h0B;
    localparam logic [7:0] MASK_BASE  = 8'h19;
    localparam logic [7:0] AUX_BASE   = 8'h1B;
    localparam logic [7:0] DRV_BASE   = 8'h2B;
    localparam logic [7:0] SNS_BASE   = 8'h33;
    localparam int         GRP_STRIDE = 16;

    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2,
        DET_BOTH = 2'd3
    } det_mode_e;

    // Drive register image, bit 5 down to bit 0.
    typedef struct packed {
        logic       dir;
        logic       od;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       val;
    } drv_cfg_t;

    function automatic logic [7:0] drv_addr(int unsigned pin);
        return DRV_BASE + 8'((pin / GRP_PINS) * GRP_STRIDE + pin % GRP_PINS);
    endfunction

    function automatic logic [7:0] sns_addr(int unsigned pin);
        return SNS_BASE + 8'((pin / GRP_PINS) * GRP_STRIDE + pin % GRP_PINS);
    endfunction

endpackage

// File: rtl/gpio_pin_sampler.sv
// Synchronises asynchronous pin levels through two flops and flags edges
// that match each pin's detection mode. Assumes pin_in may change at any time.
module gpio_pin_sampler
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      pin_in,
    input  det_mode_e [NPINS-1:0] det_mode,
    output logic [NPINS-1:0]      level,
    output logic [NPINS-1:0]      hit
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    // Two-flop synchroniser plus one-cycle history for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_edge
        logic rise, fall;
        assign rise = sync_q[p] & ~prev_q[p];
        assign fall = ~sync_q[p] & prev_q[p];

        // Qualify the raw edges with the pin's selected mode.
        always_comb begin
            unique case (det_mode[p])
                DET_FALL: hit[p] = fall;
                DET_RISE: hit[p] = rise;
                DET_BOTH: hit[p] = rise | fall;
                default:  hit[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
// Holds sticky pending bits and produces the registered interrupt.
// Assumes clr and hit are single-cycle qualified vectors; a hit beats a clear.
module gpio_irq_unit #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] clr,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] pend,
    output logic             irq
);

    logic [NPINS-1:0] pend_q;
    logic             irq_q;

    // Pending bits: clear on write-one, set on edge, edge takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | hit;
    end

    // Interrupt line: any pending bit that is not masked.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_q & ~mask);
    end

    assign pend = pend_q;
    assign irq  = irq_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
// Register file: per-pin drive and sense registers, per-group mask and
// auxiliary mask registers, pending-clear decode and registered read mux.
// Assumes at most one access per cycle; unmapped reads give zero.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int N_GRPS = 2,
    localparam int NPINS = N_GRPS * GRP_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      level,
    input  logic [NPINS-1:0]      pend,
    output drv_cfg_t [NPINS-1:0]  drv_cfg,
    output det_mode_e [NPINS-1:0] det_mode,
    output logic [NPINS-1:0]      mask,
    output logic [NPINS-1:0]      clr
);

    drv_cfg_t  [NPINS-1:0]              drv_q;
    det_mode_e [NPINS-1:0]              det_q;
    logic      [N_GRPS-1:0][GRP_PINS-1:0] mask_q;
    logic      [N_GRPS-1:0][GRP_PINS-1:0] aux_q;
    logic      [BUS_W-1:0]              rd_mux;
    logic      [BUS_W-1:0]              rdata_q;

    // Per-pin configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
            det_q <= {NPINS{DET_OFF}};
        end else if (bus_wr) begin
            for (int p = 0; p < NPINS; p++) begin
                if (bus_addr == drv_addr(p)) drv_q[p] <= drv_cfg_t'(bus_wdata[5:0]);
                if (bus_addr == sns_addr(p)) det_q[p] <= det_mode_e'(bus_wdata[2:1]);
            end
        end
    end

    // Per-group mask and auxiliary mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            aux_q  <= '1;
        end else if (bus_wr) begin
            for (int g = 0; g < N_GRPS; g++) begin
                if (bus_addr == MASK_BASE + 8'(g)) mask_q[g] <= bus_wdata;
                if (bus_addr == AUX_BASE + 8'(g))  aux_q[g]  <= bus_wdata;
            end
        end
    end

    // Write-one-to-clear decode for the pending registers.
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            clr[p] = bus_wr && (bus_addr == PEND_BASE + 8'(p / GRP_PINS))
                     && bus_wdata[p % GRP_PINS];
        end
    end

    // Read multiplexer over every mapped register; zero elsewhere.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (bus_addr == drv_addr(p)) rd_mux = {2'b00, drv_q[p]};
            if (bus_addr == sns_addr(p)) rd_mux = {5'b0, det_q[p], level[p]};
        end
        for (int g = 0; g < N_GRPS; g++) begin
            if (bus_addr == PEND_BASE + 8'(g)) rd_mux = pend[g*GRP_PINS +: GRP_PINS];
            if (bus_addr == MASK_BASE + 8'(g)) rd_mux = mask_q[g];
            if (bus_addr == AUX_BASE + 8'(g))  rd_mux = aux_q[g];
        end
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign drv_cfg   = drv_q;
    assign det_mode  = det_q;
    assign mask      = mask_q;

endmodule

// File: rtl/gpio_edge_bank.sv
// Top level of the GPIO bank controller: ties the register file, the pin
// sampler and the interrupt unit together and forms the pad-side outputs.
// Assumes synchronous active-low reset and a single clock domain for the bus.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_GRPS = 2,
    localparam int NPINS = N_GRPS * GRP_PINS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NPINS-1:0]   pin_od,
    output logic [NPINS-1:0]   pin_pull_en,
    output logic [2*NPINS-1:0] pin_pull_sel,
    output logic               irq
);

    drv_cfg_t  [NPINS-1:0] drv_cfg;
    det_mode_e [NPINS-1:0] det_mode;
    logic      [NPINS-1:0] level_vec;
    logic      [NPINS-1:0] hit_vec;
    logic      [NPINS-1:0] clr_vec;
    logic      [NPINS-1:0] mask_vec;
    logic      [NPINS-1:0] pend_vec;

    gpio_cfg_regs #(.N_GRPS(N_GRPS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .level     (level_vec),
        .pend      (pend_vec),
        .drv_cfg   (drv_cfg),
        .det_mode  (det_mode),
        .mask      (mask_vec),
        .clr       (clr_vec)
    );

    gpio_pin_sampler #(.NPINS(NPINS)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .det_mode (det_mode),
        .level    (level_vec),
        .hit      (hit_vec)
    );

    gpio_irq_unit #(.NPINS(NPINS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_vec),
        .clr   (clr_vec),
        .mask  (mask_vec),
        .pend  (pend_vec),
        .irq   (irq)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pad
        // Pad-side view of one pin's drive register.
        assign pin_out[p]           = drv_cfg[p].val;
        assign pin_oe[p]            = drv_cfg[p].dir & (~drv_cfg[p].od | ~drv_cfg[p].val);
        assign pin_od[p]            = drv_cfg[p].od;
        assign pin_pull_en[p]       = drv_cfg[p].pull_en;
        assign pin_pull_sel[2*p +: 2] = drv_cfg[p].pull_sel;
    end

endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Property checker for gpio_edge_bank, attached through bind.
// Observes ports and the internal pending, mask, edge and clear vectors.
module gpio_edge_bank_chk #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] pin_od,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] mask,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] clr
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pend == '0 && mask == '1 && !irq));

    assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_od & pin_out) == '0);

    assert_pend_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0));

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

    assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

    assert_irq_has_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(pend) != '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .pin_oe  (pin_oe),
    .pin_od  (pin_od),
    .pin_out (pin_out),
    .pend    (pend_vec),
    .mask    (mask_vec),
    .hit     (hit_vec),
    .clr     (clr_vec)
);

// File: tb/tb_gpio_edge_bank.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares it.
module tb_gpio_edge_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_od, pin_pull_en;
    logic [31:0] pin_pull_sel;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
        .pin_pull_en(pin_pull_en), .pin_pull_sel(pin_pull_sel), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected read value, then issues the read.
    task automatic bus_read(logic [7:0] a, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: after each edge that sampled a read, compare bus_rdata (R3).
    initial begin
        forever begin
            logic seen;
            @(posedge clk);
            seen = bus_rd;
            @(negedge clk);
            if (seen) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected read", 32'(bus_rdata), 32'hFFFF_FFFF);
                end else begin
                    check(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        bus_read(8'h2B, 8'h00, "R1 drive reg");
        bus_read(8'h33, 8'h00, "R1 sense reg");
        bus_read(8'h0B, 8'h00, "R1 pending0");
        bus_read(8'h19, 8'hFF, "R1 mask0");
        bus_read(8'h1A, 8'hFF, "R1 mask1");
        bus_read(8'h1C, 8'hFF, "R1 aux1");

        // R2 address map and field widths
        bus_write(8'h2E, 8'h21);               // pin 3: output, value 1
        bus_read(8'h2E, 8'h21, "R2 drive pin3");
        bus_write(8'h40, 8'hFF);               // pin 13: all drive bits
        bus_read(8'h40, 8'h3F, "R2 drive pin13 width");
        bus_write(8'h45, 8'hFF);               // pin 10 sense: both edges
        bus_read(8'h45, 8'h06, "R2 sense pin10 width");
        bus_read(8'h4B, 8'h00, "R2 unmapped 0x4B");
        bus_read(8'h00, 8'h00, "R2 unmapped 0x00");
        bus_read(8'h1D, 8'h00, "R2 unmapped 0x1D");

        // R4 push-pull drive
        check("R4 oe pin3", 32'(pin_oe[3]), 32'h1);
        check("R4 out pin3", 32'(pin_out[3]), 32'h1);
        // R5 open drain, value 1 releases
        check("R5 od released pin13", 32'(pin_oe[13]), 32'h0);
        // R6 static config outputs
        check("R6 od pin13", 32'(pin_od[13]), 32'h1);
        check("R6 pull_en pin13", 32'(pin_pull_en[13]), 32'h1);
        check("R6 pull_sel pin13", 32'(pin_pull_sel[27:26]), 32'h3);
        bus_write(8'h40, 8'h30);               // open drain, value 0
        check("R5 od drives low oe", 32'(pin_oe[13]), 32'h1);
        check("R5 od drives low out", 32'(pin_out[13]), 32'h0);
        bus_write(8'h2F, 8'h0C);               // pin 4: pull en, weak down
        check("R6 pull_en pin4", 32'(pin_pull_en[4]), 32'h1);
        check("R6 pull_sel pin4", 32'(pin_pull_sel[9:8]), 32'h2);
        check("R6 od pin4", 32'(pin_od[4]), 32'h0);
        check("R4 input pin4", 32'(pin_oe[4]), 32'h0);

        // R7 level readback
        pin_in[9] = 1'b1;
        idle(4);
        bus_read(8'h44, 8'h01, "R7 level pin9");

        // R8 detection modes: pin0 falling, pin1 rising, pin2 both
        bus_write(8'h33, 8'h02);
        bus_write(8'h34, 8'h04);
        bus_write(8'h35, 8'h06);
        pin_in[2:0] = 3'b111;
        idle(5);
        bus_read(8'h0B, 8'h06, "R8 rising edges");
        bus_write(8'h0B, 8'h06);
        bus_read(8'h0B, 8'h00, "R9 clear all");
        pin_in[2:0] = 3'b000;
        pin_in[9] = 1'b0;
        idle(5);
        bus_read(8'h0B, 8'h05, "R8 falling edges");
        bus_read(8'h0C, 8'h00, "R8 disabled pin9");

        // R11 masked pending does not interrupt
        check("R11 masked irq", 32'(irq), 32'h0);
        // R13 auxiliary mask is storage only
        bus_write(8'h1B, 8'h00);
        idle(3);
        check("R13 aux no irq", 32'(irq), 32'h0);
        bus_read(8'h1B, 8'h00, "R13 aux readback");
        bus_read(8'h1C, 8'hFF, "R13 aux other group");

        // R12 unmask pin2
        bus_write(8'h19, 8'hFB);
        idle(3);
        check("R12 irq on unmask", 32'(irq), 32'h1);
        bus_read(8'h19, 8'hFB, "R11 mask readback");
        // R9 partial clear
        bus_write(8'h0B, 8'h01);
        bus_read(8'h0B, 8'h04, "R9 partial clear");
        check("R12 irq held", 32'(irq), 32'h1);
        bus_write(8'h0B, 8'h04);
        idle(3);
        check("R12 irq drops", 32'(irq), 32'h0);
        bus_read(8'h0B, 8'h00, "R9 cleared");

        // R10 edge in same cycle as clear
        pin_in[2] = 1'b1;
        idle(5);
        bus_read(8'h0B, 8'h04, "R8 both rising");
        @(negedge clk);
        pin_in[2] = 1'b0;
        @(negedge clk);
        bus_write(8'h0B, 8'h04);               // sampled when the edge lands
        idle(4);
        bus_read(8'h0B, 8'h04, "R10 edge beats clear");
        bus_write(8'h0B, 8'h04);
        bus_read(8'h0B, 8'h00, "R9 clear after race");

        // Group 1: pin 8 rising, unmasked
        bus_write(8'h43, 8'h04);
        bus_write(8'h1A, 8'hFE);
        pin_in[8] = 1'b1;
        idle(5);
        check("R12 irq group1", 32'(irq), 32'h1);
        bus_read(8'h0C, 8'h01, "R8 group1 pending");
        bus_write(8'h0C, 8'h01);
        idle(3);
        check("R12 irq group1 clear", 32'(irq), 32'h0);

        idle(4);
        if (exp_q.size() != 0) check("R3 reads drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule